// File: doc/BRIEF.md
# Raster-Timed Register Write List Engine

This block replays a list of register writes at exact horizontal positions in a video frame, so that raster effects need no processor time. At each frame start it takes a list start address, streams list entries from memory through a byte-wide read port, and turns each entry into one write on the video controller's register bus. The position of each write is coded as a cycle distance from the previous write, so an entry only says how long to wait.

Three entry layouts are offered. Each one trades entry size against how many registers a list can reach. The engine shares the register bus with the processor, which always wins a collision. During row-fetch lines the memory bus is not available, and the engine holds off both list fetches and list writes until it is. Writes that come out later than planned are flagged as they happen. Entries are fetched ahead into a small queue, so that short distances between writes can still be met.

Top module: `raster_write_list`

## Requirements
- R1: After reset, and before the first `frame_start`, the block issues no memory read and no list write, and `list_busy` is 0.
- R2: A `frame_start` pulse samples `list_base`, `list_fmt` and `fixed_reg`. It drops any list in progress and any read in flight. No read is issued in the `frame_start` cycle. Reads then go to consecutive byte addresses starting at `list_base`. Memory returns read data one cycle after `mem_rd`.
- R3: Format code 0 (full) uses 3-byte entries: target register offset, then delay, then data value. Position 0 is the cycle after `frame_start`. An entry's planned position equals the previous entry's planned position plus its delay. For the first entry, the previous position is 0.
- R4: Format codes 1 and 3 (fixed target) use 2-byte entries: delay, then value. Every write goes to `fixed_reg`.
- R5: Format code 2 (four-register) uses 2-byte entries. Byte 0 holds a selector in bits 7:6 and a 6-bit delay in bits 5:0. Byte 1 is the value. The target is `fixed_reg` plus the selector, modulo 256.
- R6: While `bus_free` is 0, the block issues no memory read and no list write. A write that is due waits for the first cycle in which the bus is free.
- R7: A cycle with `cpu_wr` high puts the processor's address and data on the register bus. A list write due in that cycle moves to the next eligible cycle.
- R8: An entry with a delay of 0 ends the list. In full format the register byte must also be 0xFF; a 0xFF register with a non-zero delay is an ordinary write. After the end entry and any queued writes, `list_busy` falls. Reads and list writes then stop until the next `frame_start`.
- R9: `late_wr` is high exactly in list-write cycles whose position differs from the planned one. With a free bus, an entry already queued is written on time even when its delay is 1.
- R10: A `frame_start` during a running list restarts from the new base. No entry of the old list is written afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Frame start pulse; reloads and restarts the list |
| list_base | input | AW | Byte address of the first list entry |
| list_fmt | input | 2 | Entry format code |
| fixed_reg | input | 8 | Fixed target, or base register in four-register format |
| bus_free | input | 1 | Memory and register bus usable this cycle |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | AW | Byte read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| cpu_wr | input | 1 | Processor register write |
| cpu_addr | input | 8 | Processor register offset |
| cpu_wdata | input | 8 | Processor write data |
| reg_wr | output | 1 | Register bus write strobe |
| reg_addr | output | 8 | Register bus offset |
| reg_wdata | output | 8 | Register bus data |
| late_wr | output | 1 | Current list write is off its planned position |
| list_busy | output | 1 | List still being fetched or written |

## Verification
The assertions assume three things about the environment. Memory answers every read exactly one cycle later. `bus_free` truly marks the cycles in which the engine may use the bus. Reset is applied before the first frame. The bench's memory model meets the fixed latency. `bus_free` is lowered only in directed windows that begin after the queue has filled. In the random frames, delays are at least 10 cycles and processor traffic is moderate, so fetching never limits when a write can go out. This keeps the exact per-cycle write prediction valid. The one case where fetching does limit, a run of delays of 1, uses a precomputed earliest-ready cycle.

// File: rtl/rwl_pkg.sv
// Shared definitions for the register write list engine.
// Assumes list entries are stored as bytes in memory.
package rwl_pkg;

    // Entry layout selected at frame start
    typedef enum logic [1:0] {
        FMT_FULL  = 2'd0,   // register, delay, value
        FMT_FIXED = 2'd1,   // delay, value; target from fixed_reg
        FMT_QUAD  = 2'd2,   // {sel, delay6}, value; target fixed_reg+sel
        FMT_ALT   = 2'd3    // treated like FMT_FIXED
    } fmt_e;

    localparam logic [7:0] END_REG = 8'hFF;

endpackage

// File: rtl/rwl_fifo.sv
// Small prefetch queue of decoded list entries.
// Assumes the writer never pushes into a full queue; clear wins over push/pop.
module rwl_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 2,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          valid,
    output logic [NW-1:0] count
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slot_q [DEPTH];
    logic [IW-1:0] wr_q, rd_q;
    logic [NW-1:0] cnt_q;

    // One write-enabled register per slot
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_q == IW'(s))
                slot_q[s] <= din;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push)
                wr_q <= (wr_q == IW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)
                rd_q <= (rd_q == IW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (push && !pop)
                cnt_q <= cnt_q + 1'b1;
            else if (pop && !push)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign dout  = slot_q[rd_q];
    assign valid = (cnt_q != '0);
    assign count = cnt_q;

endmodule

// File: rtl/rwl_fetch.sv
// List fetcher: streams entry bytes, decodes them in the selected layout,
// chains planned positions and pushes finished entries into the queue.
// Assumes read data returns exactly one cycle after mem_rd.
module rwl_fetch
    import rwl_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 2,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [AW-1:0] list_base,
    input  logic [1:0]    list_fmt,
    input  logic [7:0]    fixed_reg,
    input  logic          bus_free,
    input  logic [NW-1:0] fifo_cnt,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          push,
    output logic [7:0]    push_reg,
    output logic [7:0]    push_val,
    output logic [CW-1:0] push_tgt,
    output logic          active
);
    fmt_e          fmt_q;
    logic [7:0]    base_reg_q;
    logic [AW-1:0] ptr_q;
    logic [1:0]    tx_q, rx_q, last_idx;
    logic          open_q, pend_q, done_q;
    logic [7:0]    b0_q, b1_q;
    logic [CW-1:0] tail_q;

    logic       rx, last_rx, is_end, end_now, room, issue;
    logic [7:0] delta;

    assign last_idx = (fmt_q == FMT_FULL) ? 2'd2 : 2'd1;

    // Decode the entry completing this cycle from held bytes plus incoming byte
    always_comb begin
        rx      = pend_q && !done_q;
        last_rx = rx && (rx_q == last_idx);
        case (fmt_q)
            FMT_FULL: begin
                push_reg = b0_q;
                delta    = b1_q;
            end
            FMT_QUAD: begin
                push_reg = base_reg_q + {6'd0, b0_q[7:6]};
                delta    = {2'b00, b0_q[5:0]};
            end
            default: begin
                push_reg = base_reg_q;
                delta    = b0_q;
            end
        endcase
        push_val = mem_rdata;
        is_end   = (delta == 8'd0) && (fmt_q != FMT_FULL || b0_q == END_REG);
        push     = last_rx && !is_end;
        end_now  = last_rx && is_end;
        push_tgt = tail_q + CW'(delta);
    end

    // Read issue: a new entry starts only with a free queue slot reserved
    always_comb begin
        room  = (int'(fifo_cnt) + int'(push)) < DEPTH;
        issue = bus_free && !frame_start && !done_q && !end_now &&
                (tx_q != 2'd0 || ((!open_q || last_rx) && room));
    end

    // Frame reload and byte stream progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q      <= FMT_FULL;
            base_reg_q <= '0;
            ptr_q      <= '0;
            tx_q       <= '0;
            rx_q       <= '0;
            open_q     <= 1'b0;
            pend_q     <= 1'b0;
            done_q     <= 1'b1;
            tail_q     <= '0;
        end else if (frame_start) begin
            fmt_q      <= fmt_e'(list_fmt);
            base_reg_q <= fixed_reg;
            ptr_q      <= list_base;
            tx_q       <= '0;
            rx_q       <= '0;
            open_q     <= 1'b0;
            pend_q     <= 1'b0;
            done_q     <= 1'b0;
            tail_q     <= '0;
        end else begin
            pend_q <= issue;
            if (issue) begin
                ptr_q <= ptr_q + 1'b1;
                tx_q  <= (tx_q == last_idx) ? 2'd0 : tx_q + 2'd1;
            end
            if (rx)
                rx_q <= (rx_q == last_idx) ? 2'd0 : rx_q + 2'd1;
            if (issue && tx_q == 2'd0)
                open_q <= 1'b1;
            else if (last_rx)
                open_q <= 1'b0;
            if (push)
                tail_q <= push_tgt;
            if (end_now)
                done_q <= 1'b1;
        end
    end

    // Capture the leading bytes of the entry being assembled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b0_q <= '0;
            b1_q <= '0;
        end else if (rx) begin
            if (rx_q == 2'd0) b0_q <= mem_rdata;
            if (rx_q == 2'd1) b1_q <= mem_rdata;
        end
    end

    assign mem_rd   = issue;
    assign mem_addr = ptr_q;
    assign active   = !done_q;

endmodule

// File: rtl/rwl_sched.sv
// Write scheduler: keeps the line position, releases the queue head when due
// and merges list writes with processor writes (processor first).
// Assumes the head entry's planned position is already absolute.
module rwl_sched #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          bus_free,
    input  logic          cpu_wr,
    input  logic [7:0]    cpu_addr,
    input  logic [7:0]    cpu_wdata,
    input  logic          head_valid,
    input  logic [7:0]    head_reg,
    input  logic [7:0]    head_val,
    input  logic [CW-1:0] head_tgt,
    output logic          pop,
    output logic          reg_wr,
    output logic [7:0]    reg_addr,
    output logic [7:0]    reg_wdata,
    output logic          late_wr
);
    logic [CW-1:0] pos_q;
    logic          fire;

    // Position counter, zero in the cycle after frame start, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start)
            pos_q <= '0;
        else if (pos_q != '1)
            pos_q <= pos_q + 1'b1;
    end

    // Release decision and bus merge
    always_comb begin
        fire    = head_valid && !frame_start && bus_free && !cpu_wr &&
                  (pos_q >= head_tgt);
        pop     = fire;
        reg_wr  = cpu_wr || fire;
        reg_addr  = cpu_wr ? cpu_addr  : head_reg;
        reg_wdata = cpu_wr ? cpu_wdata : head_val;
        late_wr = fire && (pos_q != head_tgt);
    end

endmodule

// File: rtl/raster_write_list.sv
// Top of the register write list engine: fetcher, prefetch queue, scheduler.
// Assumes one-cycle memory latency and a single shared register bus.
module raster_write_list #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [AW-1:0] list_base,
    input  logic [1:0]    list_fmt,
    input  logic [7:0]    fixed_reg,
    input  logic          bus_free,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    input  logic          cpu_wr,
    input  logic [7:0]    cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic          reg_wr,
    output logic [7:0]    reg_addr,
    output logic [7:0]    reg_wdata,
    output logic          late_wr,
    output logic          list_busy
);
    localparam int NW = $clog2(DEPTH + 1);
    localparam int EW = 16 + CW;

    logic          q_push, q_pop, q_valid, f_active;
    logic [NW-1:0] q_cnt;
    logic [7:0]    p_reg, p_val;
    logic [CW-1:0] p_tgt;
    logic [EW-1:0] q_out;

    rwl_fetch #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_fetch (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .list_base(list_base), .list_fmt(list_fmt), .fixed_reg(fixed_reg),
        .bus_free(bus_free), .fifo_cnt(q_cnt),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .push(q_push), .push_reg(p_reg), .push_val(p_val), .push_tgt(p_tgt),
        .active(f_active)
    );

    rwl_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(frame_start),
        .push(q_push), .din({p_reg, p_val, p_tgt}),
        .pop(q_pop), .dout(q_out), .valid(q_valid), .count(q_cnt)
    );

    rwl_sched #(.CW(CW)) u_sched (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .bus_free(bus_free), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .head_valid(q_valid),
        .head_reg(q_out[EW-1 -: 8]), .head_val(q_out[CW+7 -: 8]),
        .head_tgt(q_out[CW-1:0]), .pop(q_pop),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .late_wr(late_wr)
    );

    assign list_busy = f_active || q_valid;

endmodule

// File: rtl/raster_write_list_chk.sv
// Property checker for the register write list engine, bound to the top.
// Assumes memory latency of one cycle and reset asserted at start.
module raster_write_list_chk #(
    parameter int AW    = 16,
    parameter int DEPTH = 2,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic [AW-1:0] list_base,
    input logic          bus_free,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          cpu_wr,
    input logic [7:0]    cpu_addr,
    input logic [7:0]    cpu_wdata,
    input logic          reg_wr,
    input logic [7:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic          late_wr,
    input logic          list_busy,
    input logic          q_push,
    input logic [NW-1:0] q_cnt
);
    AST_READ_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> bus_free); // R6
    AST_LIST_WRITE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !cpu_wr) |-> bus_free); // R6
    AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> (reg_wr && reg_addr == cpu_addr && reg_wdata == cpu_wdata && !late_wr)); // R7
    AST_LATE_ON_LIST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        late_wr |-> (reg_wr && !cpu_wr)); // R9
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !list_busy |-> (!mem_rd && !(reg_wr && !cpu_wr))); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> (int'(q_cnt) < DEPTH)); // R9
    AST_NO_READ_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !mem_rd); // R10
    AST_FIRST_READ_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start ##1 (bus_free && !frame_start)) |->
            (mem_rd && mem_addr == $past(list_base))); // R2
endmodule

bind raster_write_list raster_write_list_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .list_base(list_base),
    .bus_free(bus_free), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .late_wr(late_wr), .list_busy(list_busy), .q_push(q_push), .q_cnt(q_cnt)
);

// File: tb/raster_write_list_bench.sv
// Self-checking bench: per-cycle reference of the register bus, driven by
// directed lists and seeded random frames.
module raster_write_list_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n, frame_start, bus_free, cpu_wr;
    logic [AW-1:0] list_base, mem_addr;
    logic [1:0]    list_fmt;
    logic [7:0]    fixed_reg, mem_rdata, cpu_addr, cpu_wdata, reg_addr, reg_wdata;
    logic          mem_rd, reg_wr, late_wr, list_busy;

    always #4 clk = ~clk;

    raster_write_list u_raster_write_list (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .list_base(list_base),
        .list_fmt(list_fmt), .fixed_reg(fixed_reg), .bus_free(bus_free),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .late_wr(late_wr), .list_busy(list_busy)
    );

    logic [7:0] mem [0:511];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];

    int n_chk = 0, n_bad = 0;
    bit fin = 0;
    int bcnt = 0, idx = 0, n_exp = 0, exp_addr = 0;
    int exp_reg [0:63], exp_val [0:63], exp_tgt [0:63], exp_min [0:63];
    int e_a [0:63], e_d [0:63], e_v [0:63];
    string cur_req = "R3";

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at pos %0d", req, act, expv, bcnt);
        end
    endtask

    // Encode staged entries into memory and build the expected write list
    task automatic load_list(input int base, input int fmt, input int fixd, input int n);
        int a = base, t = 0;
        for (int k = 0; k < n; k++) begin
            t += e_d[k];
            exp_tgt[k] = t; exp_val[k] = e_v[k]; exp_min[k] = 0;
            case (fmt)
                0: begin mem[a] = 8'(e_a[k]); mem[a+1] = 8'(e_d[k]); mem[a+2] = 8'(e_v[k]);
                         a += 3; exp_reg[k] = e_a[k]; end
                2: begin mem[a] = {2'(e_a[k]), 6'(e_d[k])}; mem[a+1] = 8'(e_v[k]);
                         a += 2; exp_reg[k] = (fixd + e_a[k]) % 256; end
                default: begin mem[a] = 8'(e_d[k]); mem[a+1] = 8'(e_v[k]);
                         a += 2; exp_reg[k] = fixd; end
            endcase
        end
        if (fmt == 0) begin mem[a] = 8'hFF; mem[a+1] = 8'h00; mem[a+2] = 8'h00; end
        else begin mem[a] = 8'h00; mem[a+1] = 8'h00; end
        n_exp = n; list_base = AW'(base); list_fmt = 2'(fmt); fixed_reg = 8'(fixd);
    endtask

    // One cycle: apply inputs, compare outputs with the reference, advance
    task automatic step(input bit fs, input bit bf, input bit cw, input int ca, input int cd);
        frame_start = fs; bus_free = bf; cpu_wr = cw;
        cpu_addr = 8'(ca); cpu_wdata = 8'(cd);
        #1;
        if (cw) begin
            chk(reg_wr && reg_addr == 8'(ca) && reg_wdata == 8'(cd) && !late_wr,
                "R7", {reg_wr, reg_addr, reg_wdata}, {1'b1, 8'(ca), 8'(cd)});
        end else if (!fs && idx < n_exp && bf && bcnt >= exp_tgt[idx] && bcnt >= exp_min[idx]) begin
            chk(reg_wr && reg_addr == 8'(exp_reg[idx]) && reg_wdata == 8'(exp_val[idx]),
                cur_req, {reg_wr, reg_addr, reg_wdata}, {1'b1, 8'(exp_reg[idx]), 8'(exp_val[idx])});
            chk(late_wr == (bcnt != exp_tgt[idx]), "R9", late_wr, bcnt != exp_tgt[idx]);
            idx++;
        end else begin
            chk(!reg_wr, bf ? cur_req : "R6", reg_wr, 0);
        end
        if (mem_rd) begin
            chk(bf && !fs, "R6", {bf, fs}, 2'b10);
            chk(mem_addr == AW'(exp_addr), "R2", mem_addr, exp_addr);
            exp_addr++;
        end
        if (fs) begin bcnt = 0; idx = 0; exp_addr = int'(list_base); end
        else bcnt++;
        @(negedge clk);
    endtask

    // Run a loaded list to completion with random processor traffic
    task automatic run_list(input int cpu_pct);
        step(1, 1, 0, 0, 0);
        for (int c = 0; c < 3000 && idx < n_exp; c++)
            step(0, 1, $urandom_range(0, 99) < cpu_pct, $urandom_range(0, 255), $urandom_range(0, 255));
        for (int c = 0; c < 8; c++) step(0, 1, 0, 0, 0);
        chk(idx == n_exp, cur_req, idx, n_exp);
        chk(!list_busy, "R8", list_busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        rst_n = 0; frame_start = 0; bus_free = 1; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
        list_base = 0; list_fmt = 0; fixed_reg = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: quiet before any frame start
        cur_req = "R1";
        for (int c = 0; c < 6; c++) begin
            step(0, 1, 0, 0, 0);
            chk(!list_busy && !mem_rd, "R1", {list_busy, mem_rd}, 0);
        end

        // R3 / R8: full format, 0xFF register with non-zero delay is a write
        cur_req = "R3";
        e_a[0] = 8'h10; e_d[0] = 12; e_v[0] = 8'hA1;
        e_a[1] = 8'hFF; e_d[1] = 5;  e_v[1] = 8'h22;
        e_a[2] = 8'h03; e_d[2] = 9;  e_v[2] = 8'h33;
        load_list(16'h000, 0, 0, 3);
        run_list(0);
        for (int c = 0; c < 20; c++) begin
            step(0, 1, 0, 0, 0);
            chk(!list_busy && !mem_rd, "R8", {list_busy, mem_rd}, 0);
        end

        // R4 / R7: fixed target, processor holds the bus at the due position
        cur_req = "R4";
        e_d[0] = 15; e_v[0] = 8'h5A; e_d[1] = 15; e_v[1] = 8'hC3;
        load_list(16'h040, 1, 8'h2C, 2);
        step(1, 1, 0, 0, 0);
        for (int c = 0; c < 60; c++)
            step(0, 1, bcnt == 15 || bcnt == 16, 8'h77, 8'h88);
        chk(idx == 2, "R7", idx, 2);

        // R5: four-register format, including wrap of the base plus selector
        cur_req = "R5";
        for (int k = 0; k < 4; k++) begin e_a[k] = k; e_d[k] = 10 + k; e_v[k] = 8'h40 + k; end
        load_list(16'h080, 2, 8'h20, 4);
        run_list(0);
        e_a[0] = 3; e_d[0] = 63; e_v[0] = 8'h9E;
        load_list(16'h0C0, 2, 8'hFE, 1);
        run_list(0);

        // R6: bus busy across a due position, fetch and write both hold off
        cur_req = "R6";
        e_d[0] = 30; e_v[0] = 8'h11; e_d[1] = 30; e_v[1] = 8'h12;
        load_list(16'h100, 1, 8'h05, 2);
        step(1, 1, 0, 0, 0);
        for (int c = 0; c < 80; c++)
            step(0, !(bcnt >= 25 && bcnt <= 34), 0, 0, 0);
        chk(idx == 2, "R6", idx, 2);

        // R9: delays of 1; second meets its position, third arrives late
        cur_req = "R9";
        e_a[0] = 8'h01; e_d[0] = 40; e_v[0] = 8'hB0;
        e_a[1] = 8'h02; e_d[1] = 1;  e_v[1] = 8'hB1;
        e_a[2] = 8'h03; e_d[2] = 1;  e_v[2] = 8'hB2;
        load_list(16'h140, 0, 0, 3);
        exp_min[2] = 45;
        run_list(0);

        // R10: restart mid-list from a new base
        cur_req = "R10";
        e_a[0] = 8'h50; e_d[0] = 20; e_v[0] = 8'hEE; e_a[1] = 8'h51; e_d[1] = 20; e_v[1] = 8'hEF;
        load_list(16'h180, 0, 0, 2);
        step(1, 1, 0, 0, 0);
        for (int c = 0; c < 10; c++) step(0, 1, 0, 0, 0);
        e_d[0] = 14; e_v[0] = 8'h61; e_d[1] = 11; e_v[1] = 8'h62;
        load_list(16'h1C0, 1, 8'h33, 2);
        run_list(0);

        // Random frames in all formats with processor traffic
        for (int f = 0; f < 6; f++) begin
            int fmt = $urandom_range(0, 2);
            cur_req = (fmt == 0) ? "R3" : (fmt == 1) ? "R4" : "R5";
            for (int k = 0; k < 12; k++) begin
                e_a[k] = (fmt == 2) ? $urandom_range(0, 3) : $urandom_range(0, 254);
                e_d[k] = $urandom_range(10, 30);
                e_v[k] = $urandom_range(0, 255);
            end
            load_list((f % 2) * 256, fmt, $urandom_range(0, 255), 12);
            run_list(25);
        end

        fin = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule